// File: doc/BRIEF.md
# Root Contention Arbitration Node

This block is the controller for one end of a point-to-point link when both ends claim the same role at once. It breaks the tie at random. The node tells its peer that it is going idle. It then draws one random bit that picks a short or a long backoff, and waits a bounded number of time ticks. After the wait it either acknowledges the peer and becomes root, or sends a request and waits for the peer's answer. When the two ends draw different speeds, the faster one acts first and the tie is broken. When they draw the same speed, the exchange can fall back into contention and a new draw is made.

Time advances only on cycles where `tick` is high. The random bit comes from outside the block; the bench uses an LFSR. Each send output is a single-cycle pulse. Each receive input is sampled on every clock edge.

The controller has nine states, held in a registered state machine. A separate wait counter counts ticks and stops at a ceiling of 168. Each speed has its own minimum and maximum wait. The node acts exactly when the count reaches the minimum, so the count never passes the maximum. The root and child outcomes hold until a synchronous reset.

Top module: `rc_arbiter_node`

## Requirements
- R1: While `rst` is high (synchronous, active high), every send output and `done`, `is_root` and `is_child` read 0, and the node starts in contention once `rst` is released.
- R2: In contention with no peer idle, the next edge pulses `tx_idle` and clears the wait count. `rand_bit` = 0 selects the fast backoff and `rand_bit` = 1 selects the slow backoff, both on the acknowledge path.
- R3: In contention with `rx_idle` high, the node moves silently to the idle-received state. On the following edge it pulses `tx_idle` and starts a backoff on the request path at the speed chosen by `rand_bit`.
- R4: Fast window: the node acts on the first edge after the wait count has reached 76 ticks. The count never exceeds 85 while a fast wait is active.
- R5: Slow window: the node acts on the first edge after the wait count has reached 159 ticks. The count never exceeds 167 while a slow wait is active.
- R6: The wait count advances only on edges where `tick` is high. While `tick` is held low short of the minimum, no send occurs.
- R7: If `rx_idle` arrives during a wait on the acknowledge path, the node switches to the request path at the same speed. The count is kept, and the request fires when the count reaches that speed's minimum.
- R8: If `rx_req` arrives during a wait on the request path, the node switches to the acknowledge path at the same speed. The count is kept, and the acknowledge fires when the count reaches that speed's minimum.
- R9: After sending a request, the node waits with no send. A peer request returns it to contention, so `tx_idle` pulses one edge later. A peer acknowledge makes it child.
- R10: In the idle-received state, a peer request sends the node back to contention instead of letting it send idle.
- R11: After an acknowledge the node is root: `is_root` and `done` stay 1. After a peer acknowledge it is child: `is_child` and `done` stay 1. In both cases no send occurs and receive inputs have no effect until reset.
- R12: Each send is a one-cycle pulse, and at most one of `tx_req`, `tx_ack` and `tx_idle` is high in any cycle. When a receive and the node's own send are both possible, the receive takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Time advance enable for the wait count |
| rand_bit | input | 1 | Random draw: 0 fast, 1 slow |
| rx_req | input | 1 | Peer request seen |
| rx_ack | input | 1 | Peer acknowledge seen |
| rx_idle | input | 1 | Peer idle seen |
| tx_req | output | 1 | Request send pulse |
| tx_ack | output | 1 | Acknowledge send pulse |
| tx_idle | output | 1 | Idle send pulse |
| done | output | 1 | A role has been settled |
| is_root | output | 1 | Node won and is root |
| is_child | output | 1 | Node lost and is child |

## Verification
The assertions assume that `rst` is high on the first clock edge. They also assume that the receive inputs only ever appear in states where the peer could legally send them. The window checks rely on the fact that no input can stretch a wait, because the node always acts at the minimum. The stimulus keeps to this. Every test starts from a reset, and receive pulses are timed from the node's own send pulses, so each one lands in a known state. `tick` is held low only while a wait is short of its minimum.

// File: rtl/rc_arb_pkg.sv
package rc_arb_pkg;

   typedef enum logic [3:0] {
      ST_CONTEND   = 4'd0,
      ST_IDLE_RX   = 4'd1,
      ST_ACKW_FAST = 4'd2,
      ST_ACKW_SLOW = 4'd3,
      ST_REQW_FAST = 4'd4,
      ST_REQW_SLOW = 4'd5,
      ST_REQ_SENT  = 4'd6,
      ST_ROOT      = 4'd7,
      ST_CHILD     = 4'd8
   } rc_state_e;

   typedef enum logic [1:0] {
      SND_NONE = 2'd0,
      SND_IDLE = 2'd1,
      SND_REQ  = 2'd2,
      SND_ACK  = 2'd3
   } rc_send_e;

   localparam int RC_NUM_SPEEDS = 2;
   localparam int RC_SPD_FAST   = 0;
   localparam int RC_SPD_SLOW   = 1;

endpackage

// File: rtl/rc_wait_timer.sv
module rc_wait_timer #(
   parameter int CNT_SAT = 168,
   parameter int CNT_W   = $clog2(CNT_SAT + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   input  logic             adv,
   output logic [CNT_W-1:0] cnt_o
);

   localparam logic [CNT_W-1:0] SAT_VAL = CNT_W'(CNT_SAT);

   initial begin
      assert (CNT_SAT >= 1) else $error("wait ceiling must be positive");
   end

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         cnt_o <= '0;
      end else if (adv && (cnt_o != SAT_VAL)) begin
         cnt_o <= cnt_o + 1'b1;
      end
   end

endmodule

// File: rtl/rc_node_fsm.sv
module rc_node_fsm
   import rc_arb_pkg::*;
(
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     rx_req,
   input  logic                     rx_ack,
   input  logic                     rx_idle,
   input  logic                     rand_bit,
   input  logic [RC_NUM_SPEEDS-1:0] reached,
   output rc_state_e                st_o,
   output logic                     tx_req_o,
   output logic                     tx_ack_o,
   output logic                     tx_idle_o,
   output logic                     clr_o,
   output logic                     wait_o,
   output logic                     slow_o
);

   rc_state_e st_q, st_d;
   rc_send_e  snd;

   assign wait_o = (st_q == ST_ACKW_FAST) || (st_q == ST_ACKW_SLOW) ||
                   (st_q == ST_REQW_FAST) || (st_q == ST_REQW_SLOW);
   assign slow_o = (st_q == ST_ACKW_SLOW) || (st_q == ST_REQW_SLOW);

   always_comb begin
      st_d  = st_q;
      snd   = SND_NONE;
      clr_o = 1'b0;
      case (st_q)
         ST_CONTEND: begin
            if (rx_idle) begin
               st_d = ST_IDLE_RX;
            end else begin
               snd   = SND_IDLE;
               clr_o = 1'b1;
               st_d  = rand_bit ? ST_ACKW_SLOW : ST_ACKW_FAST;
            end
         end
         ST_IDLE_RX: begin
            if (rx_req) begin
               st_d = ST_CONTEND;
            end else begin
               snd   = SND_IDLE;
               clr_o = 1'b1;
               st_d  = rand_bit ? ST_REQW_SLOW : ST_REQW_FAST;
            end
         end
         ST_ACKW_FAST, ST_ACKW_SLOW: begin
            if (rx_idle) begin
               st_d = slow_o ? ST_REQW_SLOW : ST_REQW_FAST;
            end else if (reached[slow_o ? RC_SPD_SLOW : RC_SPD_FAST]) begin
               snd   = SND_ACK;
               clr_o = 1'b1;
               st_d  = ST_ROOT;
            end
         end
         ST_REQW_FAST, ST_REQW_SLOW: begin
            if (rx_req) begin
               st_d = slow_o ? ST_ACKW_SLOW : ST_ACKW_FAST;
            end else if (reached[slow_o ? RC_SPD_SLOW : RC_SPD_FAST]) begin
               snd   = SND_REQ;
               clr_o = 1'b1;
               st_d  = ST_REQ_SENT;
            end
         end
         ST_REQ_SENT: begin
            if (rx_req)      st_d = ST_CONTEND;
            else if (rx_ack) st_d = ST_CHILD;
         end
         default: st_d = st_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q      <= ST_CONTEND;
         tx_req_o  <= 1'b0;
         tx_ack_o  <= 1'b0;
         tx_idle_o <= 1'b0;
      end else begin
         st_q      <= st_d;
         tx_req_o  <= (snd == SND_REQ);
         tx_ack_o  <= (snd == SND_ACK);
         tx_idle_o <= (snd == SND_IDLE);
      end
   end

   assign st_o = st_q;

   // R12: never more than one send kind in a cycle
   assert_one_kind_R12: assert property (@(posedge clk) disable iff (rst)
      $onehot0({tx_req_o, tx_ack_o, tx_idle_o}));

   // R12: a request pulse lasts exactly one cycle
   assert_req_pulse_R12: assert property (@(posedge clk) disable iff (rst)
      tx_req_o |=> !tx_req_o);

   // R2: contention without peer idle yields an idle send next
   assert_contend_idle_R2: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_CONTEND && !rx_idle) |=> tx_idle_o);

endmodule

// File: rtl/rc_arbiter_node.sv
module rc_arbiter_node
   import rc_arb_pkg::*;
#(
   parameter int FAST_MIN = 76,
   parameter int FAST_MAX = 85,
   parameter int SLOW_MIN = 159,
   parameter int SLOW_MAX = 167,
   parameter int CNT_SAT  = 168
) (
   input  logic clk,
   input  logic rst,
   input  logic tick,
   input  logic rand_bit,
   input  logic rx_req,
   input  logic rx_ack,
   input  logic rx_idle,
   output logic tx_req,
   output logic tx_ack,
   output logic tx_idle,
   output logic done,
   output logic is_root,
   output logic is_child
);

   localparam int CNT_W = $clog2(CNT_SAT + 1);
   localparam int MIN_TAB [RC_NUM_SPEEDS] = '{FAST_MIN, SLOW_MIN};

   initial begin
      assert (FAST_MIN >= 1 && FAST_MIN <= FAST_MAX) else $error("fast window malformed");
      assert (SLOW_MIN >= 1 && SLOW_MIN <= SLOW_MAX) else $error("slow window malformed");
      assert (FAST_MAX < CNT_SAT && SLOW_MAX < CNT_SAT) else $error("ceiling below a window");
   end

   logic [CNT_W-1:0]         cnt;
   logic [RC_NUM_SPEEDS-1:0] reached;
   logic                     clr, wait_en, wait_slow;
   rc_state_e                st;

   for (genvar s = 0; s < RC_NUM_SPEEDS; s++) begin : g_window
      assign reached[s] = (int'(cnt) >= MIN_TAB[s]);
   end

   rc_wait_timer #(.CNT_SAT(CNT_SAT), .CNT_W(CNT_W)) u_timer (
      .clk   (clk),
      .rst   (rst),
      .clr   (clr),
      .adv   (tick & wait_en),
      .cnt_o (cnt)
   );

   rc_node_fsm u_fsm (
      .clk       (clk),
      .rst       (rst),
      .rx_req    (rx_req),
      .rx_ack    (rx_ack),
      .rx_idle   (rx_idle),
      .rand_bit  (rand_bit),
      .reached   (reached),
      .st_o      (st),
      .tx_req_o  (tx_req),
      .tx_ack_o  (tx_ack),
      .tx_idle_o (tx_idle),
      .clr_o     (clr),
      .wait_o    (wait_en),
      .slow_o    (wait_slow)
   );

   assign is_root  = (st == ST_ROOT);
   assign is_child = (st == ST_CHILD);
   assign done     = is_root | is_child;

   // R4: a fast wait never runs past its maximum
   assert_fast_window_R4: assert property (@(posedge clk) disable iff (rst)
      (wait_en && !wait_slow) |-> (int'(cnt) <= FAST_MAX));

   // R5: a slow wait never runs past its maximum
   assert_slow_window_R5: assert property (@(posedge clk) disable iff (rst)
      (wait_en && wait_slow) |-> (int'(cnt) <= SLOW_MAX));

   // R6: without a tick, a wait that is not firing keeps its count
   assert_tick_hold_R6: assert property (@(posedge clk) disable iff (rst)
      (wait_en && !tick && !clr) |=> (cnt == $past(cnt)));

   // R11: root is absorbing and silent
   assert_root_hold_R11: assert property (@(posedge clk) disable iff (rst)
      is_root |=> (is_root && !tx_req && !tx_ack && !tx_idle));

   // R11: child is absorbing and silent
   assert_child_hold_R11: assert property (@(posedge clk) disable iff (rst)
      is_child |=> (is_child && !tx_req && !tx_ack && !tx_idle));

endmodule

// File: tb/tb_rc_arbiter_node.sv
module tb_rc_arbiter_node;

   localparam int FAST_MIN = 76;
   localparam int SLOW_MIN = 159;
   localparam logic [2:0] K_IDLE = 3'b001;
   localparam logic [2:0] K_REQ  = 3'b010;
   localparam logic [2:0] K_ACK  = 3'b100;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic tick = 1'b0, rand_bit = 1'b0;
   logic rx_req = 1'b0, rx_ack = 1'b0, rx_idle = 1'b0;
   logic tx_req, tx_ack, tx_idle, done, is_root, is_child;

   always #5 clk = ~clk;

   rc_arbiter_node dut (
      .clk(clk), .rst(rst), .tick(tick), .rand_bit(rand_bit),
      .rx_req(rx_req), .rx_ack(rx_ack), .rx_idle(rx_idle),
      .tx_req(tx_req), .tx_ack(tx_ack), .tx_idle(tx_idle),
      .done(done), .is_root(is_root), .is_child(is_child)
   );

   typedef struct {
      logic [2:0] kind;
      int         ticks;
      string      tag;
   } exp_t;

   exp_t exp_q[$];
   int compared = 0, mismatched = 0, cyc = 0, tick_acc = 0;
   logic [2:0] mon_kind;
   exp_t mon_e;
   logic [15:0] lfsr = 16'hACE1;

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (rst) tick_acc = 0;
      else if (tick) tick_acc++;
      if (cyc > 150000) begin
         compared++; mismatched++;
         $display("FAIL watchdog: run hung at cycle %0d (expected < 150000)", cyc);
         finish_run();
      end
   end

   // monitor: every send pulse is matched against the scoreboard queue
   always @(negedge clk) begin
      if (!rst && (tx_idle || tx_req || tx_ack)) begin
         mon_kind = {tx_ack, tx_req, tx_idle};
         compared++;
         if (exp_q.size() == 0) begin
            mismatched++;
            $display("FAIL R12: unexpected send %b (expected none)", mon_kind);
         end else begin
            mon_e = exp_q.pop_front();
            if (mon_kind != mon_e.kind || (mon_e.ticks >= 0 && tick_acc != mon_e.ticks)) begin
               mismatched++;
               $display("FAIL %s: send %b after %0d ticks (expected %b after %0d)",
                        mon_e.tag, mon_kind, tick_acc, mon_e.kind, mon_e.ticks);
            end
         end
         tick_acc = 0;
      end
   end

   task automatic expect_send(logic [2:0] k, int t, string tag);
      exp_t e;
      e.kind = k; e.ticks = t; e.tag = tag;
      exp_q.push_back(e);
   endtask

   task automatic check(string tag, int act, int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s: got %0d (expected %0d)", tag, act, exp);
      end
   endtask

   task automatic drain(string tag);
      int n = 0;
      while (exp_q.size() != 0 && n < 3000) begin
         @(negedge clk);
         n++;
      end
      if (exp_q.size() != 0) begin
         compared++; mismatched++;
         $display("FAIL %s: %0d sends missing (expected 0)", tag, exp_q.size());
         exp_q.delete();
      end
      @(negedge clk);
   endtask

   task automatic pulse_rx(int which);
      if (which == 0) rx_req = 1'b1;
      else if (which == 1) rx_ack = 1'b1;
      else rx_idle = 1'b1;
      @(negedge clk);
      rx_req = 1'b0; rx_ack = 1'b0; rx_idle = 1'b0;
   endtask

   task automatic reset_dut(bit idle_at_start, bit req_next);
      @(negedge clk);
      rst = 1'b1; tick = 1'b0;
      rx_req = 1'b0; rx_ack = 1'b0; rx_idle = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 outputs in reset", int'({tx_req, tx_ack, tx_idle, done, is_root, is_child}), 0);
      rst = 1'b0; tick = 1'b1; rx_idle = idle_at_start;
      if (idle_at_start) begin
         @(negedge clk);
         rx_idle = 1'b0; rx_req = req_next;
         if (req_next) begin
            @(negedge clk);
            rx_req = 1'b0;
         end
      end
   endtask

   initial begin
      // R2/R4: fast draw, straight to root
      rand_bit = 1'b0;
      expect_send(K_IDLE, -1, "R2");
      expect_send(K_ACK, FAST_MIN + 1, "R4");
      reset_dut(0, 0);
      drain("R4");
      check("R11 root", int'(is_root), 1);
      check("R11 done", int'(done), 1);
      check("R11 not child", int'(is_child), 0);
      // R11: receive pulses after root are ignored
      pulse_rx(0); pulse_rx(1); pulse_rx(2);
      repeat (10) @(negedge clk);
      check("R11 root held", int'(is_root), 1);

      // R2/R5: slow draw
      rand_bit = 1'b1;
      expect_send(K_IDLE, -1, "R2");
      expect_send(K_ACK, SLOW_MIN + 1, "R5");
      reset_dut(0, 0);
      drain("R5");
      check("R5 root", int'(is_root), 1);

      // R6: tick held low stalls the wait
      rand_bit = 1'b0;
      expect_send(K_IDLE, -1, "R6");
      expect_send(K_ACK, FAST_MIN + 1, "R6");
      reset_dut(0, 0);
      @(negedge clk);
      tick = 1'b0;
      repeat (200) @(negedge clk);
      check("R6 still waiting", int'(done), 0);
      tick = 1'b1;
      drain("R6");

      // R7/R9: peer idle mid-wait, then request, then child
      rand_bit = lfsr[0] & 1'b0;
      expect_send(K_IDLE, -1, "R7");
      expect_send(K_REQ, FAST_MIN + 1, "R7");
      reset_dut(0, 0);
      repeat (30) @(negedge clk);
      pulse_rx(2);
      drain("R7");
      check("R9 waiting after request", int'(done), 0);
      pulse_rx(1);
      repeat (2) @(negedge clk);
      check("R9 child", int'(is_child), 1);
      check("R11 child done", int'(done), 1);
      check("R9 not root", int'(is_root), 0);
      pulse_rx(0);
      repeat (5) @(negedge clk);
      check("R11 child held", int'(is_child), 1);

      // R3/R5/R9: idle seen in contention, slow request, peer request, retry fast
      rand_bit = 1'b1;
      expect_send(K_IDLE, -1, "R3");
      expect_send(K_REQ, SLOW_MIN + 1, "R5");
      expect_send(K_IDLE, -1, "R9");
      expect_send(K_ACK, FAST_MIN + 1, "R4");
      reset_dut(1, 0);
      while (!tx_req) @(negedge clk);
      rand_bit = 1'b0;
      pulse_rx(0);
      drain("R9");
      check("R9 retry root", int'(is_root), 1);

      // R8: peer request mid-wait on the request path
      rand_bit = 1'b0;
      expect_send(K_IDLE, -1, "R8");
      expect_send(K_ACK, FAST_MIN + 1, "R8");
      reset_dut(1, 0);
      repeat (20) @(negedge clk);
      pulse_rx(0);
      drain("R8");
      check("R8 root", int'(is_root), 1);

      // R10: peer request in idle-received returns to contention
      rand_bit = 1'b1;
      expect_send(K_IDLE, -1, "R10");
      expect_send(K_ACK, SLOW_MIN + 1, "R10");
      reset_dut(1, 1);
      drain("R10");
      check("R10 root", int'(is_root), 1);

      reset_dut(0, 0);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule